// File: doc/BRIEF.md
# Flash Command Sequence State Machine

This block decodes the stream of bus write events sent to a NOR-style flash device and decides which operating mode the device is in. Each write carries an address and a data byte. Two unlock writes followed by a command byte select one of four actions: a single-byte program, an identification read, a sector erase, or a return to normal reads. While an erase runs, the erase can be paused so that other sectors can be read or programmed, and it can be continued later.

The block does not hold the storage array and does not time the embedded algorithms. It sends one-cycle start, pause and continue requests to an external algorithm engine. The engine reports completion or a timing failure back to the block. For every read address the block also names the source that should drive the read data: the array, the identification codes, or the status word. The manufacturer and device codes are parameters.

The sector index is taken from the top `$clog2(N_SECT)` address bits. The unlock and command addresses are compared on the low 12 address bits.

Top module: `fcs_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `mode_o` is 0 (read array) and `rd_src_o` is 0 (array). No request pulse is raised. Reads need no command.
- R2: A write that does not match the expected next cycle of a sequence returns the machine to its idle read state. The cycles are 0xAA at 0x555, then 0x55 at 0x2AA, then the command byte at 0x555. A later command byte or data write then starts nothing.
- R3: The sequence 0xAA, 0x55, 0xA0 followed by a data write at any address gives `prog_start_o` high for exactly the one cycle after that write, with `prog_addr_o` and `prog_data_o` holding that write. `mode_o` becomes 2 (program) and `rd_src_o` becomes 2 (status).
- R4: A 0xF0 write at any address, placed between the cycles of a program, erase or identification sequence, returns to the idle read state without starting anything.
- R5: While a program or erase runs, 0xF0 writes and all other writes are ignored. The one exception is 0xB0 during an erase.
- R6: The sequence 0xAA, 0x55, 0x90 enters identification mode: `mode_o` is 1 and `rd_src_o` is 1. There `id_o` is MFR_ID at read address 0, DEV_ID at address 1, and 0 at any other address. Only a 0xF0 write leaves this mode. This holds both outside and inside a paused erase.
- R7: The sequence 0xAA, 0x55, 0x80, 0xAA, 0x55, then 0x30 at an address in sector s gives `erase_start_o` high for one cycle with `erase_sect_o` equal to s. `mode_o` becomes 3 (erase).
- R8: A 0xB0 write during an erase pulses `suspend_o` and sets `mode_o` to 4 (paused). A 0x30 write while paused pulses `resume_o` and sets `mode_o` back to 3. At any other time, 0xB0 and a lone 0x30 raise no pulse.
- R9: When the engine reports done, the block returns by itself to read array after an erase. After a program it returns to the mode that was active before the program, read array or paused.
- R10: An engine timeout during a program or an erase sets `mode_o` to 5 (error) and `rd_src_o` to 2. Only a 0xF0 write leaves the error mode. It returns to read array, or to the paused mode if the failed program was issued while paused.
- R11: While an erase is paused, a read inside the sector being erased gives `rd_src_o` 2 (status). A read in any other sector gives 0 (array). The same rule applies after a program completed while paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | One-cycle write event strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Address of the current read |
| eng_done | input | 1 | The algorithm engine finished the running operation |
| eng_timeout | input | 1 | The algorithm engine exceeded its time limit |
| mode_o | output | 3 | Mode: 0 read, 1 identification, 2 program, 3 erase, 4 paused, 5 error |
| rd_src_o | output | 2 | Read source: 0 array, 1 identification code, 2 status |
| id_o | output | 8 | Identification code for `rd_addr` |
| prog_start_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Program target address |
| prog_data_o | output | 8 | Program data byte |
| erase_start_o | output | 1 | One-cycle sector erase request |
| erase_sect_o | output | $clog2(N_SECT) | Sector to erase |
| suspend_o | output | 1 | One-cycle request to pause the erase |
| resume_o | output | 1 | One-cycle request to continue the erase |

## Verification
Most wrong sequence states cannot be seen directly, because every unlock phase reports `mode_o` as read. A wrong state only shows when the next write completes a sequence. That write then gives a request pulse one cycle too early, or no pulse where one is expected. The sequences are therefore checked by observing the pulses and `mode_o` one cycle after each closing write. A fault in the per-sector map appears in `rd_src_o` as soon as `rd_addr` moves while paused. For this reason every erased sector is crossed with every read sector.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_GO     = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_PAUSE  = 8'hB0;

  typedef enum logic [3:0] {
    ST_READ  = 4'd0,
    ST_U1    = 4'd1,
    ST_U2    = 4'd2,
    ST_PWAIT = 4'd3,
    ST_PRUN  = 4'd4,
    ST_AUTO  = 4'd5,
    ST_E0    = 4'd6,
    ST_E1    = 4'd7,
    ST_E2    = 4'd8,
    ST_ERUN  = 4'd9,
    ST_SUSP  = 4'd10,
    ST_ERR   = 4'd11
  } fcs_state_e;

  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_ID    = 3'd1,
    MD_PROG  = 3'd2,
    MD_ERASE = 3'd3,
    MD_SUSP  = 3'd4,
    MD_ERR   = 3'd5
  } fcs_mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2
  } fcs_src_e;

endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/fcs_cmd_dec.sv
module fcs_cmd_dec
  import fcs_pkg::*;
(
  input  logic [11:0] addr,
  input  logic [7:0]  data,
  output logic        key_a_hit,
  output logic        key_b_hit,
  output logic        at_cmd_addr,
  output logic        is_prog,
  output logic        is_id,
  output logic        is_esetup,
  output logic        is_go,
  output logic        is_reset,
  output logic        is_pause
);
  always_comb begin
    at_cmd_addr = (addr == UNLK_ADDR_A);
    key_a_hit   = at_cmd_addr && (data == KEY_A);
    key_b_hit   = (addr == UNLK_ADDR_B) && (data == KEY_B);
    is_prog     = (data == CMD_PROG);
    is_id       = (data == CMD_ID);
    is_esetup   = (data == CMD_ESETUP);
    is_go       = (data == CMD_GO);
    is_reset    = (data == CMD_RESET);
    is_pause    = (data == CMD_PAUSE);
  end
endmodule

// File: rtl/fcs_sector_map.sv
module fcs_sector_map #(
  parameter int N_SECT = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [SECT_W-1:0] rd_idx,
  output logic [N_SECT-1:0] sel_o,
  output logic              hit_o
);
  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = sel_o[g];
      if (clr_en)                                   bit_d = 1'b0;
      else if (set_en && (set_idx == SECT_W'(g)))   bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_o[g] <= 1'b0;
      else        sel_o[g] <= bit_d;
    end
  end

  assign hit_o = sel_o[rd_idx];
endmodule

// File: rtl/fcs_id_mux.sv
module fcs_id_mux #(
  parameter int         ADDR_W = 12,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h51
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_o
);
  always_comb begin
    if (rd_addr == '0)                 id_o = MFR_ID;
    else if (rd_addr == ADDR_W'(1))    id_o = DEV_ID;
    else                               id_o = 8'h00;
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int         ADDR_W = 12,
  parameter int         N_SECT = 8,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h51,
  parameter int         SECT_W = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              eng_done,
  input  logic              eng_timeout,
  output logic [2:0]        mode_o,
  output logic [1:0]        rd_src_o,
  output logic [7:0]        id_o,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              erase_start_o,
  output logic [SECT_W-1:0] erase_sect_o,
  output logic              suspend_o,
  output logic              resume_o
);
  logic rst_q_n;

  fcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  logic key_a_hit, key_b_hit, at_cmd_addr;
  logic is_prog, is_id, is_esetup, is_go, is_reset, is_pause;

  fcs_cmd_dec u_dec (
    .addr(wr_addr[11:0]), .data(wr_data),
    .key_a_hit(key_a_hit), .key_b_hit(key_b_hit), .at_cmd_addr(at_cmd_addr),
    .is_prog(is_prog), .is_id(is_id), .is_esetup(is_esetup), .is_go(is_go),
    .is_reset(is_reset), .is_pause(is_pause)
  );

  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic [SECT_W-1:0] wr_sect, rd_sect;
  assign wr_sect = wr_addr[ADDR_W-1:SECT_LSB];
  assign rd_sect = rd_addr[ADDR_W-1:SECT_LSB];

  fcs_state_e        st_q, st_d;
  logic              sel_set, sel_clr, rd_hit;
  logic [N_SECT-1:0] sel;

  fcs_sector_map #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_map (
    .clk(clk), .rst_n(rst_q_n), .set_en(sel_set), .set_idx(wr_sect),
    .clr_en(sel_clr), .rd_idx(rd_sect), .sel_o(sel), .hit_o(rd_hit)
  );

  fcs_id_mux #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .rd_addr(rd_addr), .id_o(id_o)
  );

  // A paused erase is the only case that leaves a marked sector outside ERUN.
  logic       in_susp;
  fcs_state_e idle_st;
  assign in_susp = (|sel) && (st_q != ST_ERUN);
  assign idle_st = in_susp ? ST_SUSP : ST_READ;

  logic prog_go_d, erase_go_d, pause_d, cont_d;

  always_comb begin
    st_d       = st_q;
    prog_go_d  = 1'b0;
    erase_go_d = 1'b0;
    pause_d    = 1'b0;
    cont_d     = 1'b0;
    sel_set    = 1'b0;
    sel_clr    = 1'b0;
    case (st_q)
      ST_READ: begin
        if (wr_en && key_a_hit) st_d = ST_U1;
      end
      ST_SUSP: begin
        if (wr_en) begin
          if (key_a_hit) st_d = ST_U1;
          else if (is_go) begin
            st_d   = ST_ERUN;
            cont_d = 1'b1;
          end
        end
      end
      ST_U1: begin
        if (wr_en) st_d = key_b_hit ? ST_U2 : idle_st;
      end
      ST_U2: begin
        if (wr_en) begin
          if (at_cmd_addr && is_prog)                    st_d = ST_PWAIT;
          else if (at_cmd_addr && is_id)                 st_d = ST_AUTO;
          else if (at_cmd_addr && is_esetup && !in_susp) st_d = ST_E0;
          else                                           st_d = idle_st;
        end
      end
      ST_PWAIT: begin
        if (wr_en) begin
          if (is_reset) st_d = idle_st;
          else begin
            st_d      = ST_PRUN;
            prog_go_d = 1'b1;
          end
        end
      end
      ST_PRUN: begin
        if (eng_timeout)   st_d = ST_ERR;
        else if (eng_done) st_d = idle_st;
      end
      ST_AUTO: begin
        if (wr_en && is_reset) st_d = idle_st;
      end
      ST_E0: begin
        if (wr_en) st_d = key_a_hit ? ST_E1 : ST_READ;
      end
      ST_E1: begin
        if (wr_en) st_d = key_b_hit ? ST_E2 : ST_READ;
      end
      ST_E2: begin
        if (wr_en) begin
          if (is_go) begin
            st_d       = ST_ERUN;
            erase_go_d = 1'b1;
            sel_set    = 1'b1;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_ERUN: begin
        if (eng_timeout) begin
          st_d    = ST_ERR;
          sel_clr = 1'b1;
        end else if (eng_done) begin
          st_d    = ST_READ;
          sel_clr = 1'b1;
        end else if (wr_en && is_pause) begin
          st_d    = ST_SUSP;
          pause_d = 1'b1;
        end
      end
      ST_ERR: begin
        if (wr_en && is_reset) st_d = idle_st;
      end
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q          <= ST_READ;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      suspend_o     <= 1'b0;
      resume_o      <= 1'b0;
    end else begin
      st_q          <= st_d;
      prog_start_o  <= prog_go_d;
      erase_start_o <= erase_go_d;
      suspend_o     <= pause_d;
      resume_o      <= cont_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prog_addr_o <= '0;
      prog_data_o <= '0;
    end else if (prog_go_d) begin
      prog_addr_o <= wr_addr;
      prog_data_o <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        erase_sect_o <= '0;
    else if (erase_go_d) erase_sect_o <= wr_sect;
  end

  fcs_mode_e mode_c;
  fcs_src_e  src_c;

  always_comb begin
    case (st_q)
      ST_AUTO: mode_c = MD_ID;
      ST_PRUN: mode_c = MD_PROG;
      ST_ERUN: mode_c = MD_ERASE;
      ST_ERR:  mode_c = MD_ERR;
      default: mode_c = in_susp ? MD_SUSP : MD_READ;
    endcase
    case (st_q)
      ST_AUTO:                  src_c = SRC_ID;
      ST_PRUN, ST_ERUN, ST_ERR: src_c = SRC_STATUS;
      default:                  src_c = (in_susp && rd_hit) ? SRC_STATUS : SRC_ARRAY;
    endcase
  end

  assign mode_o   = mode_c;
  assign rd_src_o = src_c;
endmodule

// File: rtl/fcs_seq_chk.sv
module fcs_seq_chk
  import fcs_pkg::*;
#(
  parameter int N_SECT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              eng_done,
  input logic              eng_timeout,
  input fcs_state_e        st,
  input logic              prog_start,
  input logic              erase_start,
  input logic              suspend_req,
  input logic              resume_req,
  input logic [N_SECT-1:0] sel
);
  a_r3_start_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(st == ST_PWAIT && wr_en));

  a_r5_prog_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRUN && !eng_done && !eng_timeout) |=> st == ST_PRUN);

  a_r5_erase_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERUN && !eng_done && !eng_timeout && !(wr_en && wr_data == CMD_PAUSE))
      |=> st == ST_ERUN);

  a_r6_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AUTO && !(wr_en && wr_data == CMD_RESET)) |=> st == ST_AUTO);

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start, suspend_req, resume_req}));

  a_r8_pause_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> $past(st == ST_ERUN));

  a_r8_resume_from_pause: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(st == ST_SUSP));

  a_r9_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRUN && eng_done && !eng_timeout) |=> (st == ST_READ || st == ST_SUSP));

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR && !(wr_en && wr_data == CMD_RESET)) |=> st == ST_ERR);

  a_r10_erase_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERUN && eng_timeout) |=> st == ST_ERR);

  a_r11_one_sector: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

bind fcs_seq fcs_seq_chk #(.N_SECT(N_SECT)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_data(wr_data),
  .eng_done(eng_done), .eng_timeout(eng_timeout), .st(st_q),
  .prog_start(prog_start_o), .erase_start(erase_start_o),
  .suspend_req(suspend_o), .resume_req(resume_o), .sel(sel)
);

// File: tb/tb_fcs_seq.sv
module tb_fcs_seq;
  localparam int         AW   = 12;
  localparam int         NS   = 8;
  localparam int         SW   = 3;
  localparam logic [7:0] MFR  = 8'hC2;
  localparam logic [7:0] DEV  = 8'h5A;

  logic clk, rst_n, wr_en, eng_done, eng_timeout;
  logic [AW-1:0] wr_addr, rd_addr, prog_addr_o;
  logic [7:0] wr_data, id_o, prog_data_o;
  logic [2:0] mode_o;
  logic [1:0] rd_src_o;
  logic prog_start_o, erase_start_o, suspend_o, resume_o;
  logic [SW-1:0] erase_sect_o;

  int n_run = 0;
  int n_fail = 0;

  fcs_seq #(.ADDR_W(AW), .N_SECT(NS), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .eng_done(eng_done), .eng_timeout(eng_timeout),
    .mode_o(mode_o), .rd_src_o(rd_src_o), .id_o(id_o),
    .prog_start_o(prog_start_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .erase_start_o(erase_start_o), .erase_sect_o(erase_sect_o),
    .suspend_o(suspend_o), .resume_o(resume_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic tmo_pulse();
    @(negedge clk); eng_timeout = 1'b1;
    @(negedge clk); eng_timeout = 1'b0;
  endtask

  task automatic start_erase(input int s);
    unlock(); wr(12'h555, 8'h80);
    unlock(); wr(AW'(s << (AW - SW)) | 12'h01C, 8'h30);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    eng_done = 1'b0; eng_timeout = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", int'(mode_o), 0);
    chk("R1 src in reset", int'(rd_src_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode after reset", int'(mode_o), 0);
    chk("R1 no pulses", int'({prog_start_o, erase_start_o, suspend_o, resume_o}), 0);

    // R3: program sweep over several addresses and bytes
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] pa;
      logic [7:0] pd;
      pa = AW'(k * 677 + 3);
      pd = 8'(k * 41 + 7);
      unlock(); wr(12'h555, 8'hA0);
      chk("R3 no early start", int'(prog_start_o), 0);
      wr(pa, pd);
      chk("R3 prog_start", int'(prog_start_o), 1);
      chk("R3 prog_addr", int'(prog_addr_o), int'(pa));
      chk("R3 prog_data", int'(prog_data_o), int'(pd));
      chk("R3 mode program", int'(mode_o), 2);
      chk("R3 src status", int'(rd_src_o), 2);
      @(negedge clk);
      chk("R3 pulse one cycle", int'(prog_start_o), 0);
      // R5: reset and other writes ignored while programming
      wr(12'h000, 8'hF0);
      chk("R5 reset ignored in program", int'(mode_o), 2);
      wr(12'h555, 8'hAA);
      chk("R5 write ignored in program", int'(mode_o), 2);
      done_pulse();
      chk("R9 program done to read", int'(mode_o), 0);
    end

    // R2: wrong second cycle data or address, then A0 + data must start nothing
    for (int k = 0; k < 8; k++) begin
      wr(12'h555, 8'hAA);
      if (k < 4) wr(12'h2AA, 8'(8'h50 + k));
      else       wr(AW'(12'h2AB + k), 8'h55);
      wr(12'h555, 8'hA0);
      wr(12'h123, 8'h77);
      chk("R2 mismatch no program", int'(prog_start_o), 0);
      chk("R2 mismatch mode read", int'(mode_o), 0);
    end
    // R2: wrong command address in third cycle
    unlock(); wr(12'h554, 8'h90);
    chk("R2 bad command addr", int'(mode_o), 0);

    // R4: reset at various addresses between cycles
    wr(12'h555, 8'hAA); wr(12'h7FF, 8'hF0); wr(12'h555, 8'hA0); wr(12'h010, 8'h11);
    chk("R4 reset after first unlock", int'(prog_start_o), 0);
    unlock(); wr(12'hABC, 8'hF0); wr(12'h010, 8'h11);
    chk("R4 reset after second unlock", int'(prog_start_o), 0);
    unlock(); wr(12'h555, 8'hA0); wr(12'h3A5, 8'hF0);
    chk("R4 reset before program data", int'(prog_start_o), 0);
    chk("R4 mode read", int'(mode_o), 0);
    unlock(); wr(12'h555, 8'h80); wr(12'h0F0, 8'hF0);
    unlock(); wr(12'h200, 8'h30);
    chk("R4 reset mid erase sequence", int'(erase_start_o), 0);
    chk("R4 mode stays read", int'(mode_o), 0);

    // R8: pause/continue outside an erase raise nothing
    wr(12'h000, 8'hB0);
    chk("R8 stray pause", int'(suspend_o), 0);
    wr(12'h000, 8'h30);
    chk("R8 stray resume", int'(resume_o), 0);

    // R6: identification mode
    unlock(); wr(12'h555, 8'h90);
    chk("R6 mode id", int'(mode_o), 1);
    for (int a = 0; a < 4; a++) begin
      rd_addr = AW'(a); #1;
      chk("R6 src id", int'(rd_src_o), 1);
      chk("R6 id code", int'(id_o), a == 0 ? int'(MFR) : (a == 1 ? int'(DEV) : 0));
    end
    rd_addr = 12'h800; #1;
    chk("R6 id high addr", int'(id_o), 0);
    unlock(); wr(12'h555, 8'hA0); wr(12'h004, 8'h22);
    chk("R6 sticky no program", int'(prog_start_o), 0);
    chk("R6 sticky mode", int'(mode_o), 1);
    wr(12'h999, 8'hF0);
    chk("R6 reset leaves id", int'(mode_o), 0);

    // R7, R8, R11: every erased sector against every read sector
    for (int s = 0; s < NS; s++) begin
      start_erase(s);
      chk("R7 erase_start", int'(erase_start_o), 1);
      chk("R7 erase_sect", int'(erase_sect_o), s);
      chk("R7 mode erase", int'(mode_o), 3);
      wr(12'h000, 8'hF0);
      chk("R5 reset ignored in erase", int'(mode_o), 3);
      wr(12'h000, 8'hB0);
      chk("R8 suspend pulse", int'(suspend_o), 1);
      chk("R8 mode paused", int'(mode_o), 4);
      for (int r = 0; r < NS; r++) begin
        rd_addr = AW'((r << (AW - SW)) | 5); #1;
        chk("R11 paused read source", int'(rd_src_o), (r == s) ? 2 : 0);
      end
      wr(12'h000, 8'hB0);
      chk("R8 second pause ignored", int'(suspend_o), 0);
      wr(12'h000, 8'h30);
      chk("R8 resume pulse", int'(resume_o), 1);
      chk("R8 mode erase again", int'(mode_o), 3);
      done_pulse();
      chk("R9 erase done to read", int'(mode_o), 0);
      rd_addr = AW'(s << (AW - SW)); #1;
      chk("R9 src array after erase", int'(rd_src_o), 0);
    end

    // R9, R11, R6, R10 inside a paused erase
    start_erase(2);
    wr(12'h000, 8'hB0);
    unlock(); wr(12'h555, 8'hA0); wr(12'h100, 8'h3C);
    chk("R9 program while paused", int'(prog_start_o), 1);
    chk("R9 mode program", int'(mode_o), 2);
    done_pulse();
    chk("R9 back to paused", int'(mode_o), 4);
    rd_addr = 12'h400 | 12'h011; #1;
    chk("R11 after program in sector", int'(rd_src_o), 2);
    rd_addr = 12'hA00; #1;
    chk("R11 after program outside", int'(rd_src_o), 0);
    unlock(); wr(12'h555, 8'h90);
    chk("R6 id while paused", int'(mode_o), 1);
    wr(12'h555, 8'h30);
    chk("R6 resume ignored in id", int'(resume_o), 0);
    wr(12'h000, 8'hF0);
    chk("R6 reset back to paused", int'(mode_o), 4);
    unlock(); wr(12'h555, 8'hA0); wr(12'h120, 8'h99);
    tmo_pulse();
    chk("R10 program timeout while paused", int'(mode_o), 5);
    chk("R10 src status", int'(rd_src_o), 2);
    wr(12'h000, 8'h30);
    chk("R10 write ignored in error", int'(mode_o), 5);
    wr(12'h321, 8'hF0);
    chk("R10 reset back to paused", int'(mode_o), 4);
    wr(12'h000, 8'h30);
    done_pulse();
    chk("R9 erase done after resume", int'(mode_o), 0);

    // R10 erase timeout
    start_erase(6);
    tmo_pulse();
    chk("R10 erase timeout", int'(mode_o), 5);
    unlock(); wr(12'h555, 8'h90);
    chk("R10 sequence ignored in error", int'(mode_o), 5);
    wr(12'h000, 8'hF0);
    chk("R10 reset to read", int'(mode_o), 0);
    rd_addr = 12'hC00; #1;
    chk("R10 array after recovery", int'(rd_src_o), 0);

    summary();
  end
endmodule